// File: doc/BRIEF.md
# Sticky Event Status Register with Service Request Mask

This block collects error and attention events for an instrument's remote-control interface into an 8-bit status register. Each bit belongs to one event category. A one-cycle pulse on that category's input sets the bit, and the bit stays set after the pulse has gone. The only way to clear the register is a host status query. The query returns the current contents and clears every bit on the same clock edge.

A separate 8-bit enable register selects which latched bits may raise the single service request line `status_o`. The host writes the enable register with a strobe and can read it back. A status query does not change it.

Three serial receive faults share one status bit: data overrun, noise, and a missing stop bit. A line break does not set that bit. A break sets the device-clear bit instead.

Top module: `evt_status_reg`

## Requirements
- R1: After reset, `stat_o` is 0x00, `en_rdata_o` is 0x00 and `status_o` is low.
- R2: A pulse on an event input sets its status bit on the next clock edge. The bit positions are: bit 0 execution error, bit 1 parse error, bit 2 output-queue loss, bit 3 input-buffer overrun, bit 4 serial error, bit 5 button request, bit 6 device clear, bit 7 overload.
- R3: A set status bit stays at 1 while no status query takes place, even after the event input has returned low.
- R4: While `stat_rd_i` is high, `stat_o` presents the current register value. After that clock edge, every bit that had no event pulse in the read cycle reads 0.
- R5: An event pulse in the same cycle as a status query is not lost. The query returns the old value, and the new event's bit is set after the edge.
- R6: Each of `rx_overrun_i`, `rx_noise_i` and `rx_frame_i` sets bit 4. `rx_break_i` sets bit 6 and leaves bit 4 unchanged.
- R7: Several events in one cycle set their bits independently. A repeated event on a bit that is already set leaves the register unchanged.
- R8: When `en_we_i` is high, `en_wdata_i` is stored in the enable register, and `en_rdata_o` shows it after the edge. The enable register does not change without a write, and a status query does not change it.
- R9: `status_o` is registered. One cycle after any enabled status bit is set, `status_o` is high. One cycle after no enabled bit remains set, `status_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_err_i | input | 1 | Execution error event pulse |
| parse_err_i | input | 1 | Command parse error event pulse |
| outq_lost_i | input | 1 | Output queue data lost event pulse |
| inbuf_ovf_i | input | 1 | Input buffer overrun event pulse |
| rx_overrun_i | input | 1 | Serial receiver data overrun pulse |
| rx_noise_i | input | 1 | Serial receive noise pulse |
| rx_frame_i | input | 1 | Serial missing stop bit pulse |
| rx_break_i | input | 1 | Serial line break pulse |
| button_i | input | 1 | User button request pulse |
| overload_i | input | 1 | Signal overload pulse |
| stat_rd_i | input | 1 | Status query; the register is cleared on this edge |
| stat_o | output | 8 | Current status register value |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 8 | Enable register write data |
| en_rdata_o | output | 8 | Enable register value |
| status_o | output | 1 | Registered service request |

## Verification
An event or write driven in a cycle appears on `stat_o` or `en_rdata_o` after one clock edge. `status_o` follows one edge after that, because it is registered from the stored status and enable values. The bench drives every stimulus on the falling edge. It samples `stat_o` and `en_rdata_o` at the next falling edge, and it samples `status_o` one full cycle after that. The value returned by a query is sampled during the read cycle, before the clearing edge. The cleared value is sampled one falling edge later.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int unsigned STAT_W = 8;
  localparam int unsigned BIT_EXEC   = 0;
  localparam int unsigned BIT_PARSE  = 1;
  localparam int unsigned BIT_OUTQ   = 2;
  localparam int unsigned BIT_INBUF  = 3;
  localparam int unsigned BIT_SERIAL = 4;
  localparam int unsigned BIT_BUTTON = 5;
  localparam int unsigned BIT_DCLR   = 6;
  localparam int unsigned BIT_OVLD   = 7;
  typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/evt_merge.sv
module evt_merge
  import evt_pkg::*;
(
  input  logic  exec_err_i,
  input  logic  parse_err_i,
  input  logic  outq_lost_i,
  input  logic  inbuf_ovf_i,
  input  logic  rx_overrun_i,
  input  logic  rx_noise_i,
  input  logic  rx_frame_i,
  input  logic  rx_break_i,
  input  logic  button_i,
  input  logic  overload_i,
  output stat_t set_o
);
  always_comb begin
    set_o             = '0;
    set_o[BIT_EXEC]   = exec_err_i;
    set_o[BIT_PARSE]  = parse_err_i;
    set_o[BIT_OUTQ]   = outq_lost_i;
    set_o[BIT_INBUF]  = inbuf_ovf_i;
    // break is deliberately excluded from the serial error bit
    set_o[BIT_SERIAL] = rx_overrun_i | rx_noise_i | rx_frame_i;
    set_o[BIT_BUTTON] = button_i;
    set_o[BIT_DCLR]   = rx_break_i;
    set_o[BIT_OVLD]   = overload_i;
  end
endmodule

// File: rtl/sticky_bank.sv
module sticky_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic q;
    // set wins over clear so a colliding event survives the read
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[g]) q <= 1'b1;
      else if (clr_i)    q <= 1'b0;
    end
    assign q_o[g] = q;
  end
endmodule

// File: rtl/srq_mask.sv
module srq_mask #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] stat_i,
  output logic [W-1:0] en_o,
  output logic         srq_o
);
  logic [W-1:0] en_q;
  logic         srq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (we_i) en_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) srq_q <= 1'b0;
    else         srq_q <= |(stat_i & en_q);
  end

  assign en_o  = en_q;
  assign srq_o = srq_q;
endmodule

// File: rtl/evt_status_reg.sv
module evt_status_reg
  import evt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_err_i,
  input  logic              parse_err_i,
  input  logic              outq_lost_i,
  input  logic              inbuf_ovf_i,
  input  logic              rx_overrun_i,
  input  logic              rx_noise_i,
  input  logic              rx_frame_i,
  input  logic              rx_break_i,
  input  logic              button_i,
  input  logic              overload_i,
  input  logic              stat_rd_i,
  output logic [STAT_W-1:0] stat_o,
  input  logic              en_we_i,
  input  logic [STAT_W-1:0] en_wdata_i,
  output logic [STAT_W-1:0] en_rdata_o,
  output logic              status_o
);
  stat_t set_w;
  stat_t stat_w;

  evt_merge u_merge (
    .exec_err_i   (exec_err_i),
    .parse_err_i  (parse_err_i),
    .outq_lost_i  (outq_lost_i),
    .inbuf_ovf_i  (inbuf_ovf_i),
    .rx_overrun_i (rx_overrun_i),
    .rx_noise_i   (rx_noise_i),
    .rx_frame_i   (rx_frame_i),
    .rx_break_i   (rx_break_i),
    .button_i     (button_i),
    .overload_i   (overload_i),
    .set_o        (set_w)
  );

  sticky_bank #(.W(STAT_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_w),
    .clr_i  (stat_rd_i),
    .q_o    (stat_w)
  );

  srq_mask #(.W(STAT_W)) u_srq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (en_we_i),
    .wdata_i (en_wdata_i),
    .stat_i  (stat_w),
    .en_o    (en_rdata_o),
    .srq_o   (status_o)
  );

  assign stat_o = stat_w;
endmodule

// File: rtl/evt_status_chk.sv
module evt_status_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       exec_err_i,
  input logic       rx_overrun_i,
  input logic       rx_noise_i,
  input logic       rx_frame_i,
  input logic       stat_rd_i,
  input logic [7:0] stat_o,
  input logic       en_we_i,
  input logic [7:0] en_wdata_i,
  input logic [7:0] en_rdata_o,
  input logic       status_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_CLEAN: assert (stat_o == 8'h00 && en_rdata_o == 8'h00 && !status_o); // R1
    end
  end

  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_rd_i |=> ((stat_o & $past(stat_o)) == $past(stat_o))); // R3

  AST_READ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !exec_err_i && !rx_overrun_i && !rx_noise_i && !rx_frame_i)
      |=> ((stat_o & 8'h11) == 8'h00)); // R4

  AST_READ_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && exec_err_i) |=> stat_o[0]); // R5

  AST_SERIAL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_overrun_i || rx_noise_i || rx_frame_i) |=> stat_o[4]); // R6

  AST_BREAK_NO_SERIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_o[4] && !rx_overrun_i && !rx_noise_i && !rx_frame_i) |=> !stat_o[4]); // R6

  AST_EN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_we_i |=> (en_rdata_o == $past(en_wdata_i))); // R8

  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_we_i |=> $stable(en_rdata_o)); // R8

  AST_SRQ_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (status_o == |($past(stat_o) & $past(en_rdata_o)))); // R9
endmodule

bind evt_status_reg evt_status_chk u_chk (.*);

// File: tb/sim_evt_status_reg.sv
`timescale 1ns/1ps
module sim_evt_status_reg;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] ev = '0;
  logic       stat_rd_i = 1'b0;
  logic       en_we_i = 1'b0;
  logic [7:0] en_wdata_i = '0;
  logic [7:0] stat_o, en_rdata_o;
  logic       status_o;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #5 clk_i = ~clk_i;

  // ev order: exec, parse, outq, inbuf, overrun, noise, frame, button, break, overload
  evt_status_reg u0 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .exec_err_i(ev[0]), .parse_err_i(ev[1]), .outq_lost_i(ev[2]), .inbuf_ovf_i(ev[3]),
    .rx_overrun_i(ev[4]), .rx_noise_i(ev[5]), .rx_frame_i(ev[6]), .button_i(ev[7]),
    .rx_break_i(ev[8]), .overload_i(ev[9]), .stat_rd_i(stat_rd_i), .stat_o(stat_o),
    .en_we_i(en_we_i), .en_wdata_i(en_wdata_i), .en_rdata_o(en_rdata_o), .status_o(status_o)
  );

  function automatic logic [7:0] exp_of(input logic [9:0] e);
    logic [7:0] r;
    r[0] = e[0]; r[1] = e[1]; r[2] = e[2]; r[3] = e[3];
    r[4] = e[4] | e[5] | e[6];
    r[5] = e[7]; r[6] = e[8]; r[7] = e[9];
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at falling edge, release at next falling edge (stat_o then updated)
  task automatic fire(input logic [9:0] e, input logic rd);
    @(negedge clk_i); ev = e; stat_rd_i = rd;
    @(negedge clk_i); ev = '0; stat_rd_i = 1'b0;
  endtask

  task automatic query(output logic [7:0] val);
    @(negedge clk_i); stat_rd_i = 1'b1; #1 val = stat_o;
    @(negedge clk_i); stat_rd_i = 1'b0;
  endtask

  task automatic wr_en(input logic [7:0] d);
    @(negedge clk_i); en_we_i = 1'b1; en_wdata_i = d;
    @(negedge clk_i); en_we_i = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 stat", stat_o, 8'h00);
    check("R1 en", en_rdata_o, 8'h00);
    check("R1 status", {7'd0, status_o}, 8'h00);
  endtask

  task automatic t_each_input;
    logic [7:0] v;
    for (int i = 0; i < 10; i++) begin
      fire(10'(1) << i, 1'b0);
      check((i >= 4 && i <= 6) || i == 8 ? "R6 serial/break map" : "R2 bit map",
            stat_o, exp_of(10'(1) << i));
      query(v);
    end
  endtask

  task automatic t_sticky;
    logic [7:0] v;
    fire(10'h001, 1'b0);
    repeat (3) @(negedge clk_i);
    check("R3 sticky", stat_o, 8'h01);
    query(v);
  endtask

  task automatic t_read_clear;
    logic [7:0] v;
    fire(10'h20C, 1'b0);
    query(v);
    check("R4 read value", v, 8'h8C);
    check("R4 cleared", stat_o, 8'h00);
  endtask

  task automatic t_collide;
    logic [7:0] v;
    fire(10'h002, 1'b0);
    @(negedge clk_i); stat_rd_i = 1'b1; ev = 10'h001; #1 v = stat_o;
    @(negedge clk_i); stat_rd_i = 1'b0; ev = '0;
    check("R5 old value", v, 8'h02);
    check("R5 event kept", stat_o, 8'h01);
    query(v);
  endtask

  task automatic t_multi;
    logic [7:0] v;
    fire(10'h281, 1'b0);
    check("R7 multi", stat_o, 8'hA1);
    fire(10'h001, 1'b0);
    check("R7 repeat", stat_o, 8'hA1);
    query(v);
  endtask

  task automatic t_enable;
    logic [7:0] v;
    wr_en(8'h55);
    check("R8 readback", en_rdata_o, 8'h55);
    fire(10'h001, 1'b0);
    query(v);
    check("R8 kept after query", en_rdata_o, 8'h55);
    wr_en(8'h00);
    check("R8 rewrite", en_rdata_o, 8'h00);
  endtask

  task automatic t_status;
    logic [7:0] v;
    wr_en(8'h04);
    fire(10'h002, 1'b0);
    @(negedge clk_i);
    check("R9 masked low", {7'd0, status_o}, 8'h00);
    fire(10'h004, 1'b0);
    check("R9 not yet", {7'd0, status_o}, 8'h00);
    @(negedge clk_i);
    check("R9 high", {7'd0, status_o}, 8'h01);
    query(v);
    @(negedge clk_i);
    check("R9 low after clear", {7'd0, status_o}, 8'h00);
    wr_en(8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_reset();
    t_each_input();
    t_sticky();
    t_read_clear();
    t_collide();
    t_multi();
    t_enable();
    t_status();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule